// File: doc/BRIEF.md
# Two-Section Falling-Edge Binary Counter

This block is a four-bit binary counter made of two sections that share no internal link. The low section is a single toggle stage on output bit 0, driven only by its own count input. The high section is a binary counter on output bits 3:1, driven only by a second count input, with bit 1 as its least significant bit. Each section advances when its count input goes from high to low. Rising edges do nothing.

The count inputs may be asynchronous to the system clock. Each one passes through a synchronizer, and a falling-edge detector turns it into a one-cycle count enable. Two clear-request inputs are ANDed together. When both are high, every stage flop and every edge-detector flop clears asynchronously, and both count inputs are overridden. Edges that occur while the clear is held are never counted after it is released.

To get a full divide-by-16 counter, route output bit 0 back to the high-section count input outside the block and apply pulses to the low-section input. Bits 0 to 3 then divide the input rate by 2, 4, 8 and 16. Pulses applied only to the high-section input give a divide-by-8 counter on bits 3:1. A synchronous active-low system reset also returns the block to zero.

Top module: `ripcnt_dual_section`

## Requirements
- R1: While `rst_n` is low at a clock edge, `stage_q` becomes 4'b0000.
- R2: Each falling edge on `cnt_lo_in` inverts `stage_q[0]` exactly once.
- R3: Each falling edge on `cnt_hi_in` adds one to the 3-bit value `stage_q[3:1]` (bit 1 least significant), and 7 wraps to 0.
- R4: A rising edge on either count input leaves `stage_q` unchanged.
- R5: When `clr_req_a` and `clr_req_b` are both 1, `stage_q` is 4'b0000 with no clock edge needed, and it stays zero while pulses arrive on either count input.
- R6: When exactly one of `clr_req_a`/`clr_req_b` is 1, both sections keep counting.
- R7: Pulses on `cnt_lo_in` never change `stage_q[3:1]`, and pulses on `cnt_hi_in` never change `stage_q[0]`.
- R8: With `stage_q[0]` wired to `cnt_hi_in`, the n-th pulse on `cnt_lo_in` leaves `stage_q` equal to n mod 16, stepping through 0 to 15 and wrapping to 0.
- R9: A falling edge on a count input that occurs while the clear is active is not counted after the clear is released.
- R10: A detected falling edge produces a count enable that is high for exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| cnt_lo_in | input | 1 | Count input of the toggle section (asynchronous) |
| cnt_hi_in | input | 1 | Count input of the 3-bit section (asynchronous) |
| clr_req_a | input | 1 | Clear request, first term of the AND |
| clr_req_b | input | 1 | Clear request, second term of the AND |
| stage_q | output | 4 | Stage bits; bit 0 is the toggle section, bits 3:1 are the 3-bit section |

## Verification
The main counting function is tried three ways. In cascade mode the bench ties bit 0 to the high input and applies 17 pulses, which shows whether the full 16-state sequence is ordered correctly and wraps. In divide-by-8 mode only the high input is pulsed, which separates the high section's 3-bit wrap from any leakage into bit 0. In low-only mode only the toggle input is pulsed, which confirms bits 3:1 stay put. Further patterns distinguish the two kinds of edge (a rising edge is held before the fall), distinguish the full AND clear from a single clear request, and drop a count input while the clear is held to show the hidden edge is lost.

// File: rtl/ripcnt_pkg.sv
// Package: shared sizing defaults for the two-section counter.
// Assumes: consumers derive all widths from these values.
package ripcnt_pkg;
    parameter int unsigned RC_SYNC_STAGES = 2;
    parameter int unsigned RC_HI_WIDTH    = 3;
    parameter int unsigned RC_LO_WIDTH    = 1;
endpackage

// File: rtl/ripcnt_fall_detect.sv
// Module: synchronizes one asynchronous count input and emits a one-cycle
// enable on each high-to-low transition.
// Assumes: SYNC_STAGES >= 2; clr is an asynchronous clear that also wipes the
// edge history so edges seen during clear are never reported afterwards.
module ripcnt_fall_detect #(
    parameter int unsigned SYNC_STAGES = ripcnt_pkg::RC_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic din,
    output logic fall
);
    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hist_q;

    // Synchronizer chain, one flop per stage.
    for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // Purpose: capture the raw input.
            always_ff @(posedge clk or posedge clr) begin
                if (clr)         sync_q[0] <= 1'b0;
                else if (!rst_n) sync_q[0] <= 1'b0;
                else             sync_q[0] <= din;
            end
        end else begin : g_next
            // Purpose: pass the sample one stage further.
            always_ff @(posedge clk or posedge clr) begin
                if (clr)         sync_q[i] <= 1'b0;
                else if (!rst_n) sync_q[i] <= 1'b0;
                else             sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Purpose: remember the previous synchronized sample.
    always_ff @(posedge clk or posedge clr) begin
        if (clr)         hist_q <= 1'b0;
        else if (!rst_n) hist_q <= 1'b0;
        else             hist_q <= sync_q[LAST];
    end

    // Purpose: flag previous-high, current-low.
    always_comb begin
        fall = hist_q & ~sync_q[LAST];
    end

    // R10: enable is a single-cycle pulse
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n || clr)
        fall |=> !fall);
endmodule

// File: rtl/ripcnt_toggle_stage.sv
// Module: divide-by-two section; one flop inverted on each enable.
// Assumes: en is a one-cycle pulse from the edge detector.
module ripcnt_toggle_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic q
);
    logic q_r;

    // Purpose: toggle on enable, clear on reset or master clear.
    always_ff @(posedge clk or posedge clr) begin
        if (clr)         q_r <= 1'b0;
        else if (!rst_n) q_r <= 1'b0;
        else if (en)     q_r <= ~q_r;
    end

    assign q = q_r;

    // R2: enable inverts the stage
    a_r2_toggle: assert property (@(posedge clk) disable iff (!rst_n || clr)
        en |=> (q_r != $past(q_r)));
    // R4: no enable, no change
    a_r4_hold_lo: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !en |=> $stable(q_r));
endmodule

// File: rtl/ripcnt_bin_section.sv
// Module: divide-by-2^WIDTH section; binary up-counter stepped by enable,
// wrapping from all-ones to zero.
// Assumes: en is a one-cycle pulse from the edge detector.
module ripcnt_bin_section #(
    parameter int unsigned WIDTH = ripcnt_pkg::RC_HI_WIDTH
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             en,
    output logic [WIDTH-1:0] q
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    logic [WIDTH-1:0] cnt_r;

    // Purpose: step the count on enable, clear on reset or master clear.
    always_ff @(posedge clk or posedge clr) begin
        if (clr)         cnt_r <= '0;
        else if (!rst_n) cnt_r <= '0;
        else if (en)     cnt_r <= cnt_r + ONE;
    end

    assign q = cnt_r;

    // R3: enable adds one modulo 2^WIDTH
    a_r3_increment: assert property (@(posedge clk) disable iff (!rst_n || clr)
        en |=> (cnt_r == $past(cnt_r) + ONE));
    // R4: no enable, no change
    a_r4_hold_hi: assert property (@(posedge clk) disable iff (!rst_n || clr)
        !en |=> $stable(cnt_r));
endmodule

// File: rtl/ripcnt_dual_section.sv
// Module: top of the two-section counter. It combines the two clear requests
// with an AND and routes each count input through its own edge detector to its
// own section. The sections have no internal connection; cascading is external.
// Assumes: clk is much faster than either count input.
module ripcnt_dual_section #(
    parameter int unsigned SYNC_STAGES = ripcnt_pkg::RC_SYNC_STAGES,
    parameter int unsigned HI_WIDTH    = ripcnt_pkg::RC_HI_WIDTH
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cnt_lo_in,
    input  logic                cnt_hi_in,
    input  logic                clr_req_a,
    input  logic                clr_req_b,
    output logic [HI_WIDTH:0]   stage_q
);
    localparam int unsigned OUT_W = HI_WIDTH + 1;

    logic                clr_all;
    logic                en_lo;
    logic                en_hi;
    logic                lo_q;
    logic [HI_WIDTH-1:0] hi_q;

    // Purpose: master clear fires only when both requests are high.
    always_comb begin
        clr_all = clr_req_a & clr_req_b;
    end

    ripcnt_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det_lo (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .din(cnt_lo_in), .fall(en_lo));

    ripcnt_fall_detect #(.SYNC_STAGES(SYNC_STAGES)) u_det_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .din(cnt_hi_in), .fall(en_hi));

    ripcnt_toggle_stage u_lo (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .en(en_lo), .q(lo_q));

    ripcnt_bin_section #(.WIDTH(HI_WIDTH)) u_hi (
        .clk(clk), .rst_n(rst_n), .clr(clr_all), .en(en_hi), .q(hi_q));

    assign stage_q = {hi_q, lo_q};

    // R5: a held clear keeps every stage at zero
    a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_all && $past(clr_all)) |-> (stage_q == {OUT_W{1'b0}}));
    // R7: the low enable alone never moves the high section
    a_r7_hi_isolated: assert property (@(posedge clk) disable iff (!rst_n || clr_all)
        (en_lo && !en_hi) |=> $stable(hi_q));
    // R7: the high enable alone never moves the low section
    a_r7_lo_isolated: assert property (@(posedge clk) disable iff (!rst_n || clr_all)
        (en_hi && !en_lo) |=> $stable(lo_q));
endmodule

// File: tb/sim_ripcnt_dual_section.sv
`timescale 1ns/1ps
module sim_ripcnt_dual_section;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lo_drv = 1'b0;
    logic       hi_drv = 1'b0;
    logic       cascade = 1'b0;
    logic       clr_a = 1'b0;
    logic       clr_b = 1'b0;
    logic       cnt_hi;
    logic [3:0] q;
    int         n_chk = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    assign cnt_hi = cascade ? q[0] : hi_drv;

    ripcnt_dual_section u0 (
        .clk(clk), .rst_n(rst_n), .cnt_lo_in(lo_drv), .cnt_hi_in(cnt_hi),
        .clr_req_a(clr_a), .clr_req_b(clr_b), .stage_q(q));

    task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: stage_q=%b expected %b", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_lo();
        lo_drv = 1'b1; wait_cyc(10);
        lo_drv = 1'b0; wait_cyc(14);
    endtask

    task automatic pulse_hi();
        hi_drv = 1'b1; wait_cyc(10);
        hi_drv = 1'b0; wait_cyc(14);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wait_cyc(4);
        rst_n = 1'b1; wait_cyc(2);
    endtask

    // R1: reset state
    task automatic t_reset();
        do_reset();
        chk("R1", q, 4'b0000);
    endtask

    // R2, R4, R7: low section alone
    task automatic t_low_only();
        do_reset();
        lo_drv = 1'b1; wait_cyc(10);
        chk("R4 rising low", q, 4'b0000);
        lo_drv = 1'b0; wait_cyc(14);
        chk("R2 first toggle", q, 4'b0001);
        pulse_lo();
        chk("R2 second toggle / R7 hi unchanged", q, 4'b0000);
    endtask

    // R3, R4, R7: high section alone as divide-by-8
    task automatic t_div8();
        do_reset();
        hi_drv = 1'b1; wait_cyc(10);
        chk("R4 rising high", q, 4'b0000);
        hi_drv = 1'b0; wait_cyc(14);
        chk("R3 step 1 / R7 bit0 unchanged", q, 4'b0010);
        for (int k = 2; k <= 8; k++) begin
            pulse_hi();
            chk("R3 div8 step", q, 4'((k % 8) << 1));
        end
    endtask

    // R8: cascade through 16 states and wrap
    task automatic t_cascade();
        do_reset();
        cascade = 1'b1;
        for (int k = 1; k <= 17; k++) begin
            pulse_lo();
            chk("R8 cascade", q, 4'(k % 16));
        end
        cascade = 1'b0;
    endtask

    // R5, R6: clear behaviour
    task automatic t_clear();
        do_reset();
        pulse_lo(); pulse_hi(); pulse_hi();
        chk("R6 setup", q, 4'b0101);
        clr_a = 1'b1;
        pulse_lo();
        chk("R6 clr_a alone", q, 4'b0100);
        clr_a = 1'b0; clr_b = 1'b1;
        pulse_hi();
        chk("R6 clr_b alone", q, 4'b0110);
        clr_a = 1'b1;
        #3;
        chk("R5 async clear", q, 4'b0000);
        pulse_lo(); pulse_hi();
        chk("R5 clear overrides", q, 4'b0000);
        clr_a = 1'b0; clr_b = 1'b0;
        wait_cyc(2);
    endtask

    // R9: edges during clear are lost
    task automatic t_hidden_edge();
        do_reset();
        lo_drv = 1'b1; hi_drv = 1'b1; wait_cyc(10);
        clr_a = 1'b1; clr_b = 1'b1; wait_cyc(3);
        lo_drv = 1'b0; hi_drv = 1'b0; wait_cyc(3);
        clr_a = 1'b0; clr_b = 1'b0; wait_cyc(14);
        chk("R9 hidden edge", q, 4'b0000);
        pulse_lo();
        chk("R9 counting resumes", q, 4'b0001);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        t_low_only();
        t_div8();
        t_cascade();
        t_clear();
        t_hidden_edge();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run did not complete, actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule